// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Late-Arrival Retargeting

This block runs exception entry for a small in-order core. A request is taken when its priority beats the current one. The block then lowers the stack pointer by one frame and writes an eight-word context frame through a single-cycle memory write port. It reads the handler address from a vector table through a separate read port and tells the fetch unit to start prefetching the handler. When the first handler instruction reaches execute, the block publishes the exception number and an entry-status code. It also reports the current priority throughout.

A request can arrive while an entry is still in flight, up to and including the last entry cycle. If that request has strictly higher priority, the block retargets the entry to it. It restarts the vector read and the prefetch for the new request, but it keeps the frame that is already being pushed. The frame belongs to the interrupted code and stays valid. Once the handler's first instruction is in execute, a higher-priority request is a plain pre-emption and gets a full entry with its own frame.

Arbitration among pending sources happens upstream, and the block sees only the winner. Exception return is handled elsewhere.

Top module: `ies_entry_seq`

## Requirements
- R1: After reset, `cur_pri` is all ones, `exc_num` is 0, `entry_status` is 0 (idle), and `req_ack`, `stk_wr_en`, `vec_rd_en`, `pf_start` and `exec_start` are low.
- R2: A request is acknowledged (`req_ack` high in the same cycle) only when `req_pri` is numerically lower than `cur_pri`, where a lower value means higher priority. On the next cycle `cur_pri` equals the acknowledged `req_pri`.
- R3: On a new entry, `sp_out` becomes `sp_in - 4*FRAME_WORDS` on the cycle after the acknowledge. On that cycle and the seven that follow, one frame word is written per cycle. Word k goes to `sp_out + 4k` with data `ctx_words[32k +: 32]`; k = 0..7 carries r0, r1, r2, r3, r12, LR, PC, xPSR.
- R4: On the cycle after any acknowledge, `vec_rd_en` is high with `vec_rd_addr = VEC_BASE + 4*req_num`. Read data is expected on `vec_rd_data` one cycle after the read.
- R5: Two cycles after a vector read, `pf_start` pulses with `pf_addr` equal to the word returned by that read.
- R6: Without a later takeover, `exec_start` pulses exactly nine cycles after the acknowledge cycle, which is eight entry cycles. In that cycle `exc_num` shows the entered number and `entry_status` is 1 (normal entry).
- R7: During an entry, a strictly higher-priority request is acknowledged as a late arrival. It gets a fresh vector read and prefetch, and `exec_start` comes nine cycles after its acknowledge with its number and `entry_status` 2 (late-arrival entry).
- R8: A late arrival writes no additional frame words and leaves `sp_out` unchanged, so the entry still writes exactly eight words.
- R9: During an entry, a request of equal or lower priority is not acknowledged and changes neither the vector read, the entry timing, nor the entered number.
- R10: A late arrival in the final entry cycle is still accepted, and it moves `exec_start` to nine cycles after that cycle.
- R11: A higher-priority request in or after the cycle where `exec_start` pulses is a pre-emption. It runs a full new entry with eight new frame writes and `entry_status` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Arbitrated request present |
| req_num | input | NUM_W | Exception number of the request |
| req_pri | input | PRI_W | Priority of the request (lower is more urgent) |
| req_ack | output | 1 | Request taken this cycle |
| sp_in | input | 32 | Stack pointer of the interrupted code |
| ctx_words | input | FRAME_WORDS*DATA_W | Context registers, word k at bits 32k |
| stk_wr_en | output | 1 | Frame write strobe |
| stk_wr_addr | output | 32 | Frame write address |
| stk_wr_data | output | DATA_W | Frame write data |
| vec_rd_en | output | 1 | Vector table read strobe |
| vec_rd_addr | output | 32 | Vector table read address |
| vec_rd_data | input | 32 | Vector word, valid one cycle after the read |
| pf_start | output | 1 | Start handler prefetch |
| pf_addr | output | 32 | Handler prefetch address |
| sp_out | output | 32 | Stack pointer after frame allocation |
| cur_pri | output | PRI_W | Current execution priority |
| exc_num | output | NUM_W | Exception number now executing |
| entry_status | output | 2 | 0 idle, 1 normal entry, 2 late-arrival entry |
| exec_start | output | 1 | First handler instruction in execute |

## Verification
The bench builds the block with its defaults: eight-word frame, 8-bit priority, 9-bit exception number, and the vector table at 0x400. With an eight-word frame the stacking and fetch pipelines end on the same cycle. That makes the boundary between the last late-arrival cycle and the first pre-emption cycle reachable with a single second request placed one cycle apart. The bench's memory model returns a distinct handler address per vector slot, so a retargeted prefetch shows up as a different `pf_addr`.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_NORMAL = 2'd1,
    ST_LATE   = 2'd2
  } ent_stat_e;

  // vector slot for an exception number: one word per slot
  function automatic addr_t vec_slot_addr(addr_t base, int unsigned num);
    return base + (addr_t'(num) << 2);
  endfunction

  // frame base after allocating a frame of the given word count
  function automatic addr_t frame_base(addr_t sp, int unsigned words);
    return sp - (addr_t'(words) << 2);
  endfunction

  // address of frame word k
  function automatic addr_t frame_slot(addr_t base, int unsigned k);
    return base + (addr_t'(k) << 2);
  endfunction
endpackage

// File: rtl/ies_stacker.sv
module ies_stacker
  import ies_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  parameter int DATA_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  addr_t                         base,
  input  logic [FRAME_WORDS*DATA_W-1:0] frame,
  output logic                          wr_en,
  output addr_t                         wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          busy,
  output logic                          last
);
  localparam int CW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_WORDS - 1);

  logic [DATA_W-1:0] words [FRAME_WORDS];
  logic [CW-1:0]     idx_q;
  logic              busy_q;

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_word
    assign words[g] = frame[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy    = busy_q;
  assign last    = busy_q && (idx_q == LAST_IDX);
  assign wr_en   = busy_q;
  assign wr_addr = frame_slot(base, 32'(idx_q));
  assign wr_data = words[idx_q];

  // R3: frame words land on consecutive ascending word addresses
  a_r3_consecutive_words: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && !$past(start)) |-> (wr_addr == $past(wr_addr) + 32'd4));

  // R8: a frame push is never restarted while one is running
  a_r8_no_restack: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/ies_fetcher.sv
module ies_fetcher
  import ies_pkg::*;
#(
  parameter int    NUM_W     = 9,
  parameter int    LAST_STEP = 7,
  parameter addr_t VEC_BASE  = 32'h0000_0400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  addr_t            rd_data,
  output logic             rd_en,
  output addr_t            rd_addr,
  output logic             pf_start,
  output addr_t            pf_addr,
  output logic             busy,
  output logic             last
);
  localparam int SW = $clog2(LAST_STEP + 1);
  localparam logic [SW-1:0] S_READ = SW'(0);
  localparam logic [SW-1:0] S_CAPT = SW'(1);
  localparam logic [SW-1:0] S_PREF = SW'(2);
  localparam logic [SW-1:0] S_LAST = SW'(LAST_STEP);

  logic [SW-1:0] step_q;
  logic          busy_q;
  addr_t         handler_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      step_q    <= '0;
      handler_q <= '0;
    end else begin
      if (busy_q && step_q == S_CAPT) handler_q <= rd_data;
      if (start) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        if (step_q == S_LAST) busy_q <= 1'b0;
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign last     = busy_q && (step_q == S_LAST);
  assign rd_en    = busy_q && (step_q == S_READ);
  assign rd_addr  = vec_slot_addr(VEC_BASE, 32'(num));
  assign pf_start = busy_q && (step_q == S_PREF);
  assign pf_addr  = handler_q;

  // R5: a prefetch always follows its own vector read by two cycles
  a_r5_prefetch_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    pf_start |-> $past(rd_en, 2));

  // R4: vector read happens once per (re)start, on the cycle after it
  a_r4_read_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $past(start));
endmodule

// File: rtl/ies_entry_seq.sv
module ies_entry_seq
  import ies_pkg::*;
#(
  parameter int    PRI_W       = 8,
  parameter int    NUM_W       = 9,
  parameter int    FRAME_WORDS = 8,
  parameter int    DATA_W      = 32,
  parameter addr_t VEC_BASE    = 32'h0000_0400
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [NUM_W-1:0]              req_num,
  input  logic [PRI_W-1:0]              req_pri,
  output logic                          req_ack,
  input  logic [31:0]                   sp_in,
  input  logic [FRAME_WORDS*DATA_W-1:0] ctx_words,
  output logic                          stk_wr_en,
  output logic [31:0]                   stk_wr_addr,
  output logic [DATA_W-1:0]             stk_wr_data,
  output logic                          vec_rd_en,
  output logic [31:0]                   vec_rd_addr,
  input  logic [31:0]                   vec_rd_data,
  output logic                          pf_start,
  output logic [31:0]                   pf_addr,
  output logic [31:0]                   sp_out,
  output logic [PRI_W-1:0]              cur_pri,
  output logic [NUM_W-1:0]              exc_num,
  output logic [1:0]                    entry_status,
  output logic                          exec_start
);
  localparam logic [PRI_W-1:0] PRI_THREAD = '1;
  localparam int FETCH_LAST = FRAME_WORDS - 1;

  // named internal events
  logic outranks, take_new, take_late, entering, fetch_last;
  logic stk_busy, stk_last, entry_done;

  logic [PRI_W-1:0] cur_pri_q;
  logic [NUM_W-1:0] ent_num_q, exc_num_q;
  addr_t            sp_q;
  logic             late_q, exec_q;
  ent_stat_e        status_q;

  assign outranks   = req_valid && (req_pri < cur_pri_q);
  assign take_new   = outranks && !entering;
  assign take_late  = outranks && entering;
  assign req_ack    = take_new || take_late;
  assign entry_done = fetch_last && !take_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pri_q <= PRI_THREAD;
      ent_num_q <= '0;
      exc_num_q <= '0;
      sp_q      <= '0;
      late_q    <= 1'b0;
      exec_q    <= 1'b0;
      status_q  <= ST_IDLE;
    end else begin
      if (req_ack) begin
        cur_pri_q <= req_pri;
        ent_num_q <= req_num;
      end
      if (take_new) begin
        sp_q   <= frame_base(sp_in, FRAME_WORDS);
        late_q <= 1'b0;
      end else if (take_late) begin
        late_q <= 1'b1;
      end
      exec_q <= entry_done;
      if (entry_done) begin
        exc_num_q <= ent_num_q;
        status_q  <= late_q ? ST_LATE : ST_NORMAL;
      end
    end
  end

  ies_stacker #(
    .FRAME_WORDS(FRAME_WORDS),
    .DATA_W     (DATA_W)
  ) stacker_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (take_new),
    .base   (sp_q),
    .frame  (ctx_words),
    .wr_en  (stk_wr_en),
    .wr_addr(stk_wr_addr),
    .wr_data(stk_wr_data),
    .busy   (stk_busy),
    .last   (stk_last)
  );

  ies_fetcher #(
    .NUM_W    (NUM_W),
    .LAST_STEP(FETCH_LAST),
    .VEC_BASE (VEC_BASE)
  ) fetcher_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (req_ack),
    .num     (ent_num_q),
    .rd_data (vec_rd_data),
    .rd_en   (vec_rd_en),
    .rd_addr (vec_rd_addr),
    .pf_start(pf_start),
    .pf_addr (pf_addr),
    .busy    (entering),
    .last    (fetch_last)
  );

  assign sp_out       = sp_q;
  assign cur_pri      = cur_pri_q;
  assign exc_num      = exc_num_q;
  assign entry_status = status_q;
  assign exec_start   = exec_q;

  // R2: current priority follows every accepted request
  a_r2_pri_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (cur_pri == $past(req_pri)));

  // R6: the frame is complete no later than the entry end
  a_r6_frame_before_exec: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_last |-> (!stk_busy || stk_last));

  // R6: execute marker is a single-cycle pulse with a non-idle status
  a_r6_exec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (entry_status != ST_IDLE) && !$past(exec_start));

  // R8: stack pointer is held while an entry is in flight
  a_r8_sp_held: assert property (@(posedge clk) disable iff (!rst_n)
    entering |=> $stable(sp_out));

  // R7: a late-arrival status is only reported after a takeover
  a_r7_late_status: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start && entry_status == ST_LATE) |-> late_q);
endmodule

// File: tb/ies_entry_seq_tb_top.sv
module ies_entry_seq_tb_top;
  localparam int          FW    = 8;
  localparam logic [31:0] VBASE = 32'h0000_0400;
  localparam logic [31:0] SP0   = 32'h2000_1000;

  typedef struct packed {
    int pa; int na; int dly; int pb; int nb;
    int e_num; int e_stat; int e_exec; int e_acks; int e_wr; int e_vr;
  } row_t;

  localparam row_t ROWS [7] = '{
    '{'h40, 18, 0, 0,     0,  18, 1,  9, 1,  8, 1},
    '{'h40, 18, 3, 'h20,  36, 36, 2, 12, 2,  8, 2},
    '{'h40, 18, 3, 'h40,  36, 18, 1,  9, 1,  8, 1},
    '{'h40, 18, 3, 'h60,  36, 18, 1,  9, 1,  8, 1},
    '{'h40, 18, 8, 'h10,  50, 50, 2, 17, 2,  8, 2},
    '{'h40, 18, 9, 'h10,  50, 50, 1, 18, 2, 16, 2},
    '{'h40, 18, 1, 'h3F,  20, 20, 2, 10, 2,  8, 2}
  };
  localparam string TAGS [7] = '{"R6", "R7", "R9", "R9", "R10", "R11", "R7"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [8:0] req_num = '0;
  logic [7:0] req_pri = '0;
  logic req_ack;
  logic [31:0] sp_in = SP0;
  logic [FW*32-1:0] ctx_words;
  logic stk_wr_en, vec_rd_en, pf_start, exec_start;
  logic [31:0] stk_wr_addr, stk_wr_data, vec_rd_addr, vec_rd_data, pf_addr, sp_out;
  logic [7:0] cur_pri;
  logic [8:0] exc_num;
  logic [1:0] entry_status;
  logic [31:0] vaddr_q = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_ack, n_wr, n_vr, vr_cyc, first_vr_cyc, exec_cyc;
  logic [31:0] last_va, first_va, last_pf;

  always #4 clk = ~clk;

  function automatic logic [31:0] ctx_word(int k);
    return 32'hC0DE_0000 + 32'(k * 'h111);
  endfunction
  function automatic logic [31:0] vec_mem(logic [31:0] a);
    return 32'h0001_0000 + (a << 3);
  endfunction

  for (genvar g = 0; g < FW; g++) begin : g_ctx
    assign ctx_words[g*32 +: 32] = ctx_word(g);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (vec_rd_en) vaddr_q <= vec_rd_addr;
  end
  assign vec_rd_data = vec_mem(vaddr_q);

  ies_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
    .req_pri(req_pri), .req_ack(req_ack), .sp_in(sp_in), .ctx_words(ctx_words),
    .stk_wr_en(stk_wr_en), .stk_wr_addr(stk_wr_addr), .stk_wr_data(stk_wr_data),
    .vec_rd_en(vec_rd_en), .vec_rd_addr(vec_rd_addr), .vec_rd_data(vec_rd_data),
    .pf_start(pf_start), .pf_addr(pf_addr), .sp_out(sp_out), .cur_pri(cur_pri),
    .exc_num(exc_num), .entry_status(entry_status), .exec_start(exec_start)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor, sampling at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_ack) n_ack++;
      if (stk_wr_en) begin
        chk(stk_wr_addr == SP0 - 32 + 32'((n_wr % FW) * 4), "R3 frame address",
            stk_wr_addr, SP0 - 32 + 32'((n_wr % FW) * 4));
        chk(stk_wr_data == ctx_word(n_wr % FW), "R3 frame data", stk_wr_data, ctx_word(n_wr % FW));
        n_wr++;
      end
      if (vec_rd_en) begin
        if (n_vr == 0) begin first_va = vec_rd_addr; first_vr_cyc = cyc; end
        n_vr++; last_va = vec_rd_addr; vr_cyc = cyc;
      end
      if (pf_start) begin
        chk(cyc - vr_cyc == 2, "R5 prefetch delay", 64'(cyc - vr_cyc), 64'd2);
        chk(pf_addr == vec_mem(last_va), "R5 prefetch address", pf_addr, vec_mem(last_va));
        last_pf = pf_addr;
      end
      if (exec_start) exec_cyc = cyc;
    end
  end

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    n_ack = 0; n_wr = 0; n_vr = 0; vr_cyc = 0; first_vr_cyc = 0; exec_cyc = -1;
    last_va = '0; first_va = '0; last_pf = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    chk(cur_pri == 8'hFF, "R1 cur_pri", cur_pri, 8'hFF);
    chk(exc_num == 0, "R1 exc_num", exc_num, 0);
    chk(entry_status == 0, "R1 status", entry_status, 0);
    chk({req_ack, stk_wr_en, vec_rd_en, pf_start, exec_start} == 0, "R1 strobes",
        {req_ack, stk_wr_en, vec_rd_en, pf_start, exec_start}, 0);

    // R2: a request equal to the idle priority is refused
    @(posedge clk); #2;
    req_valid = 1'b1; req_pri = 8'hFF; req_num = 9'd5;
    @(negedge clk);
    chk(req_ack == 1'b0, "R2 equal priority refused", req_ack, 0);
    @(posedge clk); #2 req_valid = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(n_wr == 0 && n_vr == 0, "R2 no entry started", 64'(n_wr + n_vr), 0);
    chk(entry_status == 0, "R2 status stays idle", entry_status, 0);

    // table of scenarios
    for (int r = 0; r < 7; r++) begin
      int t0;
      do_reset();
      @(posedge clk); #2;
      req_valid = 1'b1; req_pri = 8'(ROWS[r].pa); req_num = 9'(ROWS[r].na);
      t0 = cyc;
      @(negedge clk);
      chk(req_ack == 1'b1, "R2 higher priority taken", req_ack, 1);
      for (int i = 1; i < 28; i++) begin
        @(posedge clk); #2;
        req_valid = (ROWS[r].dly == i);
        req_pri = 8'(ROWS[r].pb); req_num = 9'(ROWS[r].nb);
        if (i == 1) begin
          @(negedge clk);
          chk(cur_pri == 8'(ROWS[r].pa), "R2 cur_pri follows", cur_pri, ROWS[r].pa);
        end
      end
      @(negedge clk);
      chk(exec_cyc - t0 == ROWS[r].e_exec, {TAGS[r], " exec timing"}, 64'(exec_cyc - t0), 64'(ROWS[r].e_exec));
      chk(exc_num == 9'(ROWS[r].e_num), {TAGS[r], " exc_num"}, exc_num, ROWS[r].e_num);
      chk(entry_status == 2'(ROWS[r].e_stat), {TAGS[r], " status"}, entry_status, ROWS[r].e_stat);
      chk(n_ack == ROWS[r].e_acks, {TAGS[r], " acknowledges"}, 64'(n_ack), 64'(ROWS[r].e_acks));
      chk(n_wr == ROWS[r].e_wr, "R8 frame word count", 64'(n_wr), 64'(ROWS[r].e_wr));
      chk(sp_out == SP0 - 32, "R8 sp_out", sp_out, SP0 - 32);
      chk(n_vr == ROWS[r].e_vr, {TAGS[r], " vector reads"}, 64'(n_vr), 64'(ROWS[r].e_vr));
      chk(first_va == VBASE + 32'(ROWS[r].na * 4), "R4 first vector address", first_va, VBASE + 32'(ROWS[r].na * 4));
      chk(first_vr_cyc - t0 == 1, "R4 vector read cycle", 64'(first_vr_cyc - t0), 1);
      chk(last_va == VBASE + 32'(ROWS[r].e_num * 4), {TAGS[r], " final vector"}, last_va, VBASE + 32'(ROWS[r].e_num * 4));
      chk(last_pf == vec_mem(VBASE + 32'(ROWS[r].e_num * 4)), {TAGS[r], " final prefetch"},
          last_pf, vec_mem(VBASE + 32'(ROWS[r].e_num * 4)));
      chk(cur_pri == 8'((ROWS[r].e_acks == 2) ? ROWS[r].pb : ROWS[r].pa), {TAGS[r], " cur_pri"},
          cur_pri, (ROWS[r].e_acks == 2) ? ROWS[r].pb : ROWS[r].pa);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule